// File: doc/BRIEF.md
# Serial Flash Status and Configuration Register Writer

This block is the register back end of a serial flash device model. It sits behind an SPI slave shifter. From the chip-select level, a per-bit strobe and the byte that each eighth strobe completes, it works out which command a frame carried. It also counts how many bits the frame held when chip select went high. It keeps four registers: one status register and three configuration registers. Each has a non-volatile copy and a live volatile copy. From these it drives the quad-width and all-quad-instruction mode flags that the shifter uses.

A register write only lands when an earlier, separate frame has armed the write-enable latch. The frame must also close exactly on a byte boundary. For the multi-register write, the byte at which chip select rises decides how many registers are updated. Any other frame length cancels the write. Each accepted write starts a short busy window that stands in for the programming time. A power-on pulse copies the non-volatile values into the live registers. A read-any-register frame brings out either copy through a small read port.

Top module: `flash_cfg_regs`

## Requirements
- R1: An opcode 0x06 frame sets the write-enable latch (status bit 1) only when chip select rises after exactly 8 bits. Any other length leaves the latch unchanged.
- R2: Register-write frames that arrive while the write-enable latch is clear are discarded. No register changes and the latch stays clear.
- R3: Opcode 0x01 followed by N data bytes, closed after 8+8N bits with N from 1 to 4, writes the first N registers in the order status, config-1, config-2, config-3. It writes both the non-volatile and the volatile copy. The other registers keep their values.
- R4: An opcode 0x01 frame that closes off a byte boundary, with no data byte, or with more than 4 data bytes changes nothing and leaves the write-enable latch set.
- R5: An accepted write clears the write-enable latch. It sets write-in-progress (status bit 0) for exactly BUSY_CYCLES clock cycles. Written values for status bits 1:0 are ignored.
- R6: While write-in-progress is set, every frame except a register read is ignored. This includes write-enable and the mode commands.
- R7: Opcode 0x71, an address byte and a data byte, closed after exactly 24 bits, write one register. Addresses 0x00 to 0x03 select the non-volatile copy only. Addresses 0x80 to 0x83 select the volatile copy only. Any other address discards the frame and keeps the latch set.
- R8: An 8-bit frame with opcode 0x38 sets volatile config-2 bit 3, and one with 0xF5 clears it. Neither needs the write-enable latch. Frames of any other length do nothing.
- R9: qpi_o follows volatile config-2 bit 3. quad_o is high when volatile config-1 bit 1 or config-2 bit 3 is set.
- R10: A power-on pulse loads every volatile register from its non-volatile copy. It also clears the write-enable latch and write-in-progress.
- R11: Opcode 0x65 followed by an address byte raises rd_valid_o for one cycle, one clock after the address byte completes, with the addressed register on rd_data_o (same map as R7; volatile status shows live bits 1:0). An unmapped address reads 0.
- R12: Reset loads both copies from NV_INIT (default status 0x00, config-1 0x00, config-2 0x60, config-3 0x78) and clears the latch and write-in-progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on pulse: reload volatile registers |
| cs_n_i | input | 1 | Chip select level, active low |
| bit_stb_i | input | 1 | One bit latched by the shifter this cycle |
| rx_byte_i | input | 8 | Completed byte, valid with every eighth strobe |
| sr1_o | output | 8 | Live status register (bit 0 busy, bit 1 write enable) |
| cr1_o | output | 8 | Live config-1 register |
| cr2_o | output | 8 | Live config-2 register |
| cr3_o | output | 8 | Live config-3 register |
| quad_o | output | 1 | Four-bit data width active |
| qpi_o | output | 1 | Four-bit instruction width active |
| rd_valid_o | output | 1 | Read-any-register result valid |
| rd_data_o | output | 8 | Read-any-register result |

## Verification
The hardest state to reach is a non-volatile copy that differs from its live copy. Neither register write alone produces it, and the live outputs never show the non-volatile side. The stimulus writes a single non-volatile register through the addressed write. It then observes the split through the read frame and finally through a power-on pulse that promotes the value into the mode flags. A second hard case is a command that arrives inside the busy window. The bench runs with a long busy count so that whole mode and write-enable frames fit inside it.

// File: rtl/flashreg_pkg.sv
`timescale 1ns/1ps
package flashreg_pkg;

    localparam int NREG = 4;

    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_WRR     = 8'h01;
    localparam logic [7:0] OP_WRAR    = 8'h71;
    localparam logic [7:0] OP_RDAR    = 8'h65;
    localparam logic [7:0] OP_QPI_ON  = 8'h38;
    localparam logic [7:0] OP_QPI_OFF = 8'hF5;

    localparam int SR1_WIP  = 0;
    localparam int SR1_WEL  = 1;
    localparam int CR1_QUAD = 1;
    localparam int CR2_QPI  = 3;
    localparam int CR1_IDX  = 1;
    localparam int CR2_IDX  = 2;
    localparam int ADDR_VOL = 7;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRR,
        CMD_WRAR,
        CMD_QPI_ON,
        CMD_QPI_OFF
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e            kind;
        logic [2:0]           nregs;
        logic [7:0]           addr;
        logic [NREG-1:0][7:0] data;
    } reg_cmd_t;

    // Status bits 1:0 are owned by hardware; writes never reach them.
    function automatic logic [7:0] wr_mask(input int idx, input logic [7:0] d);
        return (idx == 0) ? {d[7:2], 2'b00} : d;
    endfunction

endpackage

// File: rtl/flashreg_frame.sv
`timescale 1ns/1ps
module flashreg_frame #(
    parameter int CNT_W = 6,
    localparam int IDX_W = CNT_W - 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             bit_stb,
    output logic             byte_done,
    output logic [IDX_W-1:0] byte_idx,
    output logic             frame_end,
    output logic             frame_aligned,
    output logic [IDX_W-1:0] frame_bytes
);
    logic [CNT_W-1:0] cnt_q;
    logic             cs_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            cs_n_q <= 1'b1;
        end else begin
            cs_n_q <= cs_n;
            if (cs_n)
                cnt_q <= '0;
            else if (bit_stb && (cnt_q != '1))
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign byte_done     = !cs_n && bit_stb && (cnt_q[2:0] == 3'd7);
    assign byte_idx      = cnt_q[CNT_W-1:3];
    assign frame_end     = cs_n && !cs_n_q;
    assign frame_aligned = (cnt_q[2:0] == 3'd0);
    assign frame_bytes   = cnt_q[CNT_W-1:3];

    // A deselected bus must always hold an empty bit count (frame boundary, R4)
    assert_idle_count_R4: assert property (@(posedge clk) disable iff (rst)
        cs_n_q |-> (cnt_q == '0));

endmodule

// File: rtl/flashreg_decode.sv
`timescale 1ns/1ps
module flashreg_decode
    import flashreg_pkg::*;
#(
    parameter int CNT_W = 6,
    localparam int IDX_W = CNT_W - 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       rx_byte,
    input  logic             byte_done,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic             frame_end,
    input  logic             frame_aligned,
    input  logic [IDX_W-1:0] frame_bytes,
    output reg_cmd_t         cmd,
    output logic             rd_req,
    output logic [7:0]       rd_addr
);
    logic [7:0]           op_q;
    logic [NREG-1:0][7:0] dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= '0;
            dat_q <= '0;
        end else if (byte_done) begin
            if (byte_idx == '0)
                op_q <= rx_byte;
            for (int i = 0; i < NREG; i++)
                if (int'(byte_idx) == i + 1)
                    dat_q[i] <= rx_byte;
        end
    end

    always_comb begin
        cmd      = '0;
        cmd.kind = CMD_NONE;
        cmd.data = dat_q;
        cmd.addr = dat_q[0];
        if (frame_end && frame_aligned) begin
            unique case (op_q)
                OP_WREN:    if (int'(frame_bytes) == 1) cmd.kind = CMD_WREN;
                OP_QPI_ON:  if (int'(frame_bytes) == 1) cmd.kind = CMD_QPI_ON;
                OP_QPI_OFF: if (int'(frame_bytes) == 1) cmd.kind = CMD_QPI_OFF;
                OP_WRR: begin
                    if (int'(frame_bytes) >= 2 && int'(frame_bytes) <= NREG + 1) begin
                        cmd.kind  = CMD_WRR;
                        cmd.nregs = 3'(int'(frame_bytes) - 1);
                    end
                end
                OP_WRAR: begin
                    if (int'(frame_bytes) == 3) begin
                        cmd.kind    = CMD_WRAR;
                        cmd.data[0] = dat_q[1];
                    end
                end
                default: cmd.kind = CMD_NONE;
            endcase
        end
    end

    assign rd_req  = byte_done && (int'(byte_idx) == 1) && (op_q == OP_RDAR);
    assign rd_addr = rx_byte;

    // A frame closed off a byte boundary never yields a command (R4)
    assert_misaligned_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !frame_aligned) |-> (cmd.kind == CMD_NONE));

    // A multi-register write carries one to four registers (R3)
    assert_wrr_span_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind == CMD_WRR) |-> (cmd.nregs >= 3'd1 && int'(cmd.nregs) <= NREG));

endmodule

// File: rtl/flashreg_bank.sv
`timescale 1ns/1ps
module flashreg_bank
    import flashreg_pkg::*;
#(
    parameter int                   BUSY_CYCLES = 8,
    parameter logic [NREG*8-1:0]    NV_INIT     = 32'h7860_0000,
    localparam int BW    = $clog2(BUSY_CYCLES + 1),
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por,
    input  reg_cmd_t             cmd,
    input  logic                 rd_req,
    input  logic [7:0]           rd_addr,
    output logic [NREG-1:0][7:0] live,
    output logic                 rd_valid,
    output logic [7:0]           rd_data
);
    logic [NREG-1:0][7:0] nv_q, v_q;
    logic                 wel_q;
    logic [BW-1:0]        busy_q;
    logic                 wip;
    logic [7:0]           rd_val;
    logic [IDX_W-1:0]     wa_idx, rd_idx;
    logic                 wa_ok, rd_ok;

    assign wip    = (busy_q != '0);
    assign wa_idx = cmd.addr[IDX_W-1:0];
    assign wa_ok  = (cmd.addr[ADDR_VOL-1:IDX_W] == '0);
    assign rd_idx = rd_addr[IDX_W-1:0];
    assign rd_ok  = (rd_addr[ADDR_VOL-1:IDX_W] == '0);

    always_comb begin
        live               = v_q;
        live[0][SR1_WIP]   = wip;
        live[0][SR1_WEL]   = wel_q;
    end

    always_comb begin
        rd_val = 8'h00;
        if (rd_ok)
            rd_val = rd_addr[ADDR_VOL] ? live[rd_idx] : nv_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q     <= NV_INIT;
            v_q      <= NV_INIT;
            wel_q    <= 1'b0;
            busy_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req)
                rd_data <= rd_val;
            if (por) begin
                v_q    <= nv_q;
                wel_q  <= 1'b0;
                busy_q <= '0;
            end else if (wip) begin
                busy_q <= busy_q - BW'(1);
            end else begin
                unique case (cmd.kind)
                    CMD_WREN:    wel_q <= 1'b1;
                    CMD_QPI_ON:  v_q[CR2_IDX][CR2_QPI] <= 1'b1;
                    CMD_QPI_OFF: v_q[CR2_IDX][CR2_QPI] <= 1'b0;
                    CMD_WRR: begin
                        if (wel_q) begin
                            for (int i = 0; i < NREG; i++) begin
                                if (i < int'(cmd.nregs)) begin
                                    nv_q[i] <= wr_mask(i, cmd.data[i]);
                                    v_q[i]  <= wr_mask(i, cmd.data[i]);
                                end
                            end
                            wel_q  <= 1'b0;
                            busy_q <= BW'(BUSY_CYCLES);
                        end
                    end
                    CMD_WRAR: begin
                        if (wel_q && wa_ok) begin
                            if (cmd.addr[ADDR_VOL])
                                v_q[wa_idx]  <= wr_mask(int'(wa_idx), cmd.data[0]);
                            else
                                nv_q[wa_idx] <= wr_mask(int'(wa_idx), cmd.data[0]);
                            wel_q  <= 1'b0;
                            busy_q <= BW'(BUSY_CYCLES);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Entering the busy window always drops the write-enable latch (R5)
    assert_wel_drop_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> !wel_q);

    // Nothing but the busy count moves while a write is in progress (R6)
    assert_busy_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (wip && !por) |=> ($stable(nv_q) && $stable(v_q)));

    // Non-volatile contents only change when the latch was armed (R2)
    assert_nv_needs_wel_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(nv_q) |-> $past(wel_q));

    // The latch only rises after a write-enable command (R1)
    assert_wel_source_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(wel_q) |-> $past(cmd.kind == CMD_WREN));

endmodule

// File: rtl/flash_cfg_regs.sv
`timescale 1ns/1ps
module flash_cfg_regs
    import flashreg_pkg::*;
#(
    parameter int                CNT_W       = 6,
    parameter int                BUSY_CYCLES = 8,
    parameter logic [NREG*8-1:0] NV_INIT     = 32'h7860_0000,
    localparam int IDX_W = CNT_W - 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_i,
    input  logic       cs_n_i,
    input  logic       bit_stb_i,
    input  logic [7:0] rx_byte_i,
    output logic [7:0] sr1_o,
    output logic [7:0] cr1_o,
    output logic [7:0] cr2_o,
    output logic [7:0] cr3_o,
    output logic       quad_o,
    output logic       qpi_o,
    output logic       rd_valid_o,
    output logic [7:0] rd_data_o
);
    logic                 byte_done, frame_end, frame_aligned;
    logic [IDX_W-1:0]     byte_idx, frame_bytes;
    reg_cmd_t             cmd;
    logic                 rd_req;
    logic [7:0]           rd_addr;
    logic [NREG-1:0][7:0] live;

    flashreg_frame #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst(rst), .cs_n(cs_n_i), .bit_stb(bit_stb_i),
        .byte_done(byte_done), .byte_idx(byte_idx), .frame_end(frame_end),
        .frame_aligned(frame_aligned), .frame_bytes(frame_bytes)
    );

    flashreg_decode #(.CNT_W(CNT_W)) u_decode (
        .clk(clk), .rst(rst), .rx_byte(rx_byte_i), .byte_done(byte_done),
        .byte_idx(byte_idx), .frame_end(frame_end), .frame_aligned(frame_aligned),
        .frame_bytes(frame_bytes), .cmd(cmd), .rd_req(rd_req), .rd_addr(rd_addr)
    );

    flashreg_bank #(.BUSY_CYCLES(BUSY_CYCLES), .NV_INIT(NV_INIT)) u_bank (
        .clk(clk), .rst(rst), .por(por_i), .cmd(cmd), .rd_req(rd_req),
        .rd_addr(rd_addr), .live(live), .rd_valid(rd_valid_o), .rd_data(rd_data_o)
    );

    assign sr1_o  = live[0];
    assign cr1_o  = live[CR1_IDX];
    assign cr2_o  = live[CR2_IDX];
    assign cr3_o  = live[3];
    assign qpi_o  = live[CR2_IDX][CR2_QPI];
    assign quad_o = live[CR1_IDX][CR1_QUAD] | live[CR2_IDX][CR2_QPI];

endmodule

// File: tb/flash_cfg_regs_bench.sv
`timescale 1ns/1ps
module flash_cfg_regs_bench;
    localparam int BUSY = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por = 1'b0;
    logic cs_n = 1'b1;
    logic bit_stb = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] sr1, cr1, cr2, cr3, rd_data;
    logic quad, qpi, rd_valid;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_nv [4];
    logic [7:0] m_v  [4];
    bit rd_seen;
    logic [7:0] rd_val;

    always #10 clk = ~clk;

    flash_cfg_regs #(.BUSY_CYCLES(BUSY)) u_flash_cfg_regs (
        .clk(clk), .rst(rst), .por_i(por), .cs_n_i(cs_n), .bit_stb_i(bit_stb),
        .rx_byte_i(rx_byte), .sr1_o(sr1), .cr1_o(cr1), .cr2_o(cr2), .cr3_o(cr3),
        .quad_o(quad), .qpi_o(qpi), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
    );

    always @(negedge clk) if (rd_valid) begin rd_seen = 1'b1; rd_val = rd_data; end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input int nbits, input logic [47:0] b);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            cs_n = 1'b0;
            bit_stb = 1'b1;
            if (i % 8 == 7) rx_byte = b[47 - 8*(i/8) -: 8];
        end
        @(negedge clk);
        bit_stb = 1'b0;
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wren();
        send(8, {8'h06, 40'h0});
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 1000 && sr1[0]; k++) @(negedge clk);
    endtask

    task automatic pulse_por();
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0;
        for (int i = 0; i < 4; i++) m_v[i] = m_nv[i];
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_seen = 1'b0;
        send(16, {8'h65, a, 32'h0});
        d = rd_seen ? rd_val : 8'hxx;
    endtask

    task automatic chk_live(input string tag, input bit wel);
        chk({tag, " sr1"}, sr1, m_v[0] | {6'b0, wel, 1'b0});
        chk({tag, " cr1"}, cr1, m_v[1]);
        chk({tag, " cr2"}, cr2, m_v[2]);
        chk({tag, " cr3"}, cr3, m_v[3]);
    endtask

    task automatic t_reset();
        m_nv = '{8'h00, 8'h00, 8'h60, 8'h78};
        m_v  = m_nv;
        chk_live("R12 reset", 1'b0);
        chk("R12 quad/qpi", {quad, qpi}, 2'b00);
    endtask

    task automatic t_wren();
        send(16, {8'h06, 8'h00, 32'h0});
        chk("R1 16-bit wren ignored", sr1[1], 1'b0);
        wren();
        chk("R1 wren sets latch", sr1[1], 1'b1);
        pulse_por();
        chk("R10 por clears latch", sr1[1], 1'b0);
    endtask

    task automatic t_no_wel();
        send(16, {8'h01, 8'hF0, 32'h0});
        chk_live("R2 wrr without latch", 1'b0);
        send(24, {8'h71, 8'h81, 8'h02, 24'h0});
        chk_live("R2 wrar without latch", 1'b0);
    endtask

    task automatic t_wrr_len();
        logic [7:0] vals [4][4];
        logic [7:0] d;
        vals[0] = '{8'hA7, 8'h00, 8'h00, 8'h00};
        vals[1] = '{8'h10, 8'h00, 8'h00, 8'h00};
        vals[2] = '{8'h20, 8'h40, 8'h61, 8'h00};
        vals[3] = '{8'h30, 8'h05, 8'h70, 8'h5A};
        for (int n = 1; n <= 4; n++) begin
            logic [47:0] fr;
            fr = {8'h01, vals[n-1][0], vals[n-1][1], vals[n-1][2], vals[n-1][3], 8'h00};
            wren();
            send(8 + 8*n, fr);
            for (int i = 0; i < n; i++) begin
                m_nv[i] = (i == 0) ? {vals[n-1][i][7:2], 2'b00} : vals[n-1][i];
                m_v[i]  = m_nv[i];
            end
            if (n == 1) begin
                chk("R5 wip set, latch cleared", sr1[1:0], 2'b01);
                chk("R5 status low bits masked", sr1 & 8'hFC, 8'hA4);
            end
            wait_idle();
            chk_live($sformatf("R3 wrr %0d regs", n), 1'b0);
        end
        for (int i = 0; i < 4; i++) begin
            rd(8'(i), d);
            chk($sformatf("R3 nv copy %0d", i), d, m_nv[i]);
        end
    endtask

    task automatic t_misaligned();
        wren();
        send(20, {8'h01, 8'hCC, 8'hCC, 24'h0});
        chk_live("R4 20-bit wrr dropped", 1'b1);
        send(8, {8'h01, 40'h0});
        chk_live("R4 opcode-only wrr dropped", 1'b1);
        send(48, {8'h01, 8'hEC, 8'h11, 8'h22, 8'h33, 8'h44});
        chk_live("R4 over-long wrr dropped", 1'b1);
        send(16, {8'h01, 8'h88, 32'h0});
        m_nv[0] = 8'h88; m_v[0] = 8'h88;
        wait_idle();
        chk_live("R4 latch survived drops", 1'b0);
    endtask

    task automatic t_busy();
        int cycles;
        wren();
        send(16, {8'h01, 8'h44, 32'h0});
        m_nv[0] = 8'h44; m_v[0] = 8'h44;
        chk("R5 busy status", sr1, 8'h45);
        send(8, {8'h38, 40'h0});
        chk("R6 qpi enter ignored when busy", qpi, 1'b0);
        send(8, {8'h06, 40'h0});
        chk("R6 wren ignored when busy", sr1[1], 1'b0);
        wait_idle();
        chk_live("R6 after busy", 1'b0);
        wren();
        send(16, {8'h01, 8'h48, 32'h0});
        m_nv[0] = 8'h48; m_v[0] = 8'h48;
        cycles = 0;
        while (sr1[0] && cycles < 1000) begin @(negedge clk); cycles++; end
        chk("R5 busy length", cycles, BUSY);
    endtask

    task automatic t_qpi();
        send(8, {8'h38, 40'h0});
        chk("R8 qpi enter", {qpi, cr2[3]}, 2'b11);
        chk("R9 qpi forces quad", quad, 1'b1);
        send(8, {8'hF5, 40'h0});
        chk("R8 qpi exit", {qpi, quad}, 2'b00);
        send(16, {8'h38, 8'h00, 32'h0});
        chk("R8 16-bit enter ignored", qpi, 1'b0);
    endtask

    task automatic t_wrar();
        logic [7:0] d;
        wren();
        send(24, {8'h71, 8'h01, 8'h06, 24'h0});
        m_nv[1] = 8'h06;
        wait_idle();
        chk_live("R7 nv write leaves live", 1'b0);
        chk("R7 quad stays off", quad, 1'b0);
        rd(8'h01, d);
        chk("R11 read nv cr1", d, 8'h06);
        rd(8'h81, d);
        chk("R11 read live cr1", d, 8'h05);
        wren();
        send(24, {8'h71, 8'h81, 8'h06, 24'h0});
        m_v[1] = 8'h06;
        wait_idle();
        chk_live("R7 volatile write", 1'b0);
        chk("R9 quad from cr1", {quad, qpi}, 2'b10);
        wren();
        send(24, {8'h71, 8'h42, 8'hFF, 24'h0});
        chk_live("R7 bad address dropped", 1'b1);
        send(24, {8'h71, 8'h02, 8'h68, 24'h0});
        m_nv[2] = 8'h68;
        wait_idle();
        chk("R7 live qpi untouched", qpi, 1'b0);
        rd(8'h10, d);
        chk("R11 unmapped reads zero", d, 8'h00);
        rd(8'h80, d);
        chk("R11 live status", d, m_v[0]);
    endtask

    task automatic t_por();
        pulse_por();
        @(negedge clk);
        chk_live("R10 por reload", 1'b0);
        chk("R10 qpi from nv", {qpi, quad}, 2'b11);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wren();
        t_no_wel();
        t_wrr_len();
        t_misaligned();
        t_busy();
        t_qpi();
        t_wrar();
        t_por();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule